// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This unit evaluates the set-flag compare instructions of a processor on two single-precision floating-point operands. Each operand pair is placed in exactly one of four relations: equal, less, greater or unordered. A three-bit predicate code then selects which relations make the condition flag true. The relational predicates are ordered, so a NaN operand forces them false, while not-equal reports true on an unordered pair.

A compare also updates the floating-point status word. The surrounding pipeline presents the current status word and gets back the updated one. The invalid-operation bit is set whenever either operand is NaN. The quiet-NaN bit and every other bit pass through unchanged, because that bit belongs to arithmetic operations. Results are registered and appear one cycle after the input strobe, together with an output valid.

Top module: `fcmp_flag_unit`

## Requirements
- R1: An operand is NaN only when its exponent field (bits 30:23) is all ones and its fraction field (bits 22:0) is nonzero. An infinity, which has an all-ones exponent and a zero fraction, is not NaN and does not set the invalid bit.
- R2: Each pair of non-NaN operands falls into exactly one of the relations equal, less or greater. Two identical encodings are equal. Predicate codes are: 0 equal, 1 not-equal, 2 greater, 3 greater-or-equal, 4 less, 5 less-or-equal.
- R3: If either operand is NaN the pair is unordered, and predicates 2, 3, 4 and 5 give a false flag.
- R4: On an unordered pair, predicate 1 (not-equal) gives a true flag and predicate 0 (equal) gives a false flag.
- R5: Positive zero and negative zero compare equal. All other non-NaN values are ordered by sign and magnitude, and denormals are compared by their raw encodings without flushing to zero.
- R6: Infinities order above (positive) or below (negative) every finite value. An infinity compares equal to an infinity of the same sign.
- R7: When either operand is NaN, statusOut bit INV_BIT (default 4) is 1. Otherwise that bit equals the corresponding bit of statusIn.
- R8: Every statusOut bit other than INV_BIT equals the corresponding bit of statusIn. This includes the quiet-NaN bit, which the bench places at bit 2.
- R9: outValid, condFlag and statusOut reset to 0. outValid is 1 exactly in the cycle after a cycle with inValid high. condFlag and statusOut change only in that cycle and hold their values otherwise.
- R10: Predicate codes 6 and 7 give a false flag for any operands.
- R11: For any operands, the ordered greater flag equals the negation of unordered less-or-equal, where unordered less-or-equal is true when either operand is NaN or the ordered less-or-equal flag is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and predicate are valid this cycle |
| predSel | input | 3 | Predicate code (see R2) |
| opA | input | 32 | First operand, single-precision encoding |
| opB | input | 32 | Second operand, single-precision encoding |
| statusIn | input | 8 | Current floating-point status word |
| outValid | output | 1 | Result valid, one cycle after inValid |
| condFlag | output | 1 | Condition flag result |
| statusOut | output | 8 | Updated status word |

## Verification
The bench sends quiet and signalling NaNs of both signs, the smallest-fraction NaN, both zeros, both infinities, denormals and finite values of both signs through every predicate code. It checks each result against an independent key-based reference model. A design that treats infinity as NaN would set the invalid bit on infinite operands. One that compares zeros by raw bits would call -0 less than +0. A design without the ordered rule would report greater or less on NaN pairs. One that misreads sign-magnitude order would invert the result for two negative operands. Random pairs, close neighbours and deliberate greater/less-or-equal pairs exercise the ordered-greater identity and check that status bits other than the invalid bit are left alone.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam logic [2:0] PRED_EQ = 3'd0;
  localparam logic [2:0] PRED_NE = 3'd1;
  localparam logic [2:0] PRED_GT = 3'd2;
  localparam logic [2:0] PRED_GE = 3'd3;
  localparam logic [2:0] PRED_LT = 3'd4;
  localparam logic [2:0] PRED_LE = 3'd5;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  // Strobes from control to datapath: which relations make the flag true.
  typedef struct packed {
    logic load;
    logic acceptEq;
    logic acceptLt;
    logic acceptGt;
    logic acceptUn;
  } cmp_strobe_t;

endpackage

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [2:0]  predSel,
  output cmp_strobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe = '0;
    strobe.load = inValid;
    case (predSel)
      PRED_EQ: strobe.acceptEq = 1'b1;
      PRED_NE: begin
        strobe.acceptLt = 1'b1;
        strobe.acceptGt = 1'b1;
        strobe.acceptUn = 1'b1;
      end
      PRED_GT: strobe.acceptGt = 1'b1;
      PRED_GE: begin
        strobe.acceptGt = 1'b1;
        strobe.acceptEq = 1'b1;
      end
      PRED_LT: strobe.acceptLt = 1'b1;
      PRED_LE: begin
        strobe.acceptLt = 1'b1;
        strobe.acceptEq = 1'b1;
      end
      default: ;  // reserved codes select no relation
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  a_r10_reserved_none: assert property (@(posedge clk) disable iff (!rst_n)
    (predSel[2:1] == 2'b11) |-> !(strobe.acceptEq || strobe.acceptLt || strobe.acceptGt || strobe.acceptUn));

endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int EXP_W    = 8,
  parameter int FRAC_W   = 23,
  parameter int STATUS_W = 8,
  parameter int INV_BIT  = 4,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  cmp_strobe_t         strobe,
  input  logic [W-1:0]        opA,
  input  logic [W-1:0]        opB,
  input  logic [STATUS_W-1:0] statusIn,
  output logic                condFlag,
  output logic [STATUS_W-1:0] statusOut
);

  localparam int MAG_W = W - 1;

  logic [1:0][W-1:0] opnd;
  logic [1:0]        isNan;
  logic [1:0]        isZero;
  logic [1:0]        isInf;

  assign opnd[0] = opA;
  assign opnd[1] = opB;

  for (genvar i = 0; i < 2; i++) begin : g_class
    assign isNan[i]  = (&opnd[i][W-2:FRAC_W]) && (|opnd[i][FRAC_W-1:0]);
    assign isInf[i]  = (&opnd[i][W-2:FRAC_W]) && !(|opnd[i][FRAC_W-1:0]);
    assign isZero[i] = ~|opnd[i][MAG_W-1:0];
  end

  logic             nanAny;
  logic             signA, signB;
  logic [MAG_W-1:0] magA, magB;
  logic             magAGreater;
  rel_e             rel;

  assign nanAny      = |isNan;
  assign signA       = opA[W-1];
  assign signB       = opB[W-1];
  assign magA        = opA[MAG_W-1:0];
  assign magB        = opB[MAG_W-1:0];
  assign magAGreater = magA > magB;

  always_comb begin
    if (nanAny)                      rel = REL_UN;
    else if ((&isZero) || opA == opB) rel = REL_EQ;
    else if (signA != signB)          rel = signA ? REL_LT : REL_GT;
    else if (!signA)                  rel = magAGreater ? REL_GT : REL_LT;
    else                              rel = magAGreater ? REL_LT : REL_GT;
  end

  logic                flagNext;
  logic [STATUS_W-1:0] statusNext;

  always_comb begin
    case (rel)
      REL_EQ:  flagNext = strobe.acceptEq;
      REL_LT:  flagNext = strobe.acceptLt;
      REL_GT:  flagNext = strobe.acceptGt;
      default: flagNext = strobe.acceptUn;
    endcase
  end

  always_comb begin
    for (int k = 0; k < STATUS_W; k++) begin
      statusNext[k] = statusIn[k] | ((k == INV_BIT) && nanAny);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      condFlag  <= 1'b0;
      statusOut <= '0;
    end else if (strobe.load) begin
      condFlag  <= flagNext;
      statusOut <= statusNext;
    end
  end

  a_r7_invalid_on_nan: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load && nanAny |=> statusOut[INV_BIT]);
  a_r1_inf_not_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load && (&isInf) && !statusIn[INV_BIT] |=> !statusOut[INV_BIT]);
  a_r3_ordered_false: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load && nanAny && !strobe.acceptUn |=> !condFlag);
  a_r5_zero_equal: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load && (&isZero) |=> condFlag == $past(strobe.acceptEq));
  a_r2_same_bits_equal: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load && !nanAny && opA == opB |=> condFlag == $past(strobe.acceptEq));
  a_r8_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> (statusOut & ~(STATUS_W'(1) << INV_BIT)) ==
                    $past(statusIn & ~(STATUS_W'(1) << INV_BIT)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> $stable(condFlag) && $stable(statusOut));

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W    = 8,
  parameter int FRAC_W   = 23,
  parameter int STATUS_W = 8,
  parameter int INV_BIT  = 4,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic [2:0]          predSel,
  input  logic [W-1:0]        opA,
  input  logic [W-1:0]        opB,
  input  logic [STATUS_W-1:0] statusIn,
  output logic                outValid,
  output logic                condFlag,
  output logic [STATUS_W-1:0] statusOut
);

  cmp_strobe_t strobe;

  fcmp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .predSel  (predSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fcmp_datapath #(
    .EXP_W    (EXP_W),
    .FRAC_W   (FRAC_W),
    .STATUS_W (STATUS_W),
    .INV_BIT  (INV_BIT)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .statusIn  (statusIn),
    .condFlag  (condFlag),
    .statusOut (statusOut)
  );

endmodule

// File: tb/fcmp_flag_unit_tb.sv
`timescale 1ns/1ps
module fcmp_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inValid;
  logic [2:0]  predSel;
  logic [31:0] opA, opB;
  logic [7:0]  statusIn;
  logic        outValid, condFlag;
  logic [7:0]  statusOut;

  always #2.5 clk = ~clk;

  fcmp_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .predSel(predSel),
    .opA(opA), .opB(opB), .statusIn(statusIn),
    .outValid(outValid), .condFlag(condFlag), .statusOut(statusOut)
  );

  int total = 0;
  int bad   = 0;

  bit    expFlag[$];
  bit [7:0] expStat[$];
  string flagTag[$];
  string statTag[$];
  bit    obsFlag[$];
  int    pairIdx[$];
  bit    pairNan[$];
  int    sent = 0;
  bit    lastFlag;

  function automatic bit refNan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic bit refInf(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] == 0);
  endfunction

  function automatic logic [31:0] orderKey(logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    if (x[31])        return ~x;
    return x | 32'h8000_0000;
  endfunction

  function automatic bit refFlag(logic [31:0] a, logic [31:0] b, logic [2:0] p);
    logic [31:0] ka, kb;
    if (refNan(a) || refNan(b)) return (p == 3'd1);
    ka = orderKey(a);
    kb = orderKey(b);
    case (p)
      3'd0: return ka == kb;
      3'd1: return ka != kb;
      3'd2: return ka > kb;
      3'd3: return ka >= kb;
      3'd4: return ka < kb;
      3'd5: return ka <= kb;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [31:0] a, logic [31:0] b, logic [2:0] p, logic [7:0] st);
    bit nan;
    string ft, stt;
    nan = refNan(a) || refNan(b);
    if (p > 3'd5)                ft = "R10";
    else if (nan)                ft = (p < 3'd2) ? "R4" : "R3";
    else if (refInf(a) || refInf(b)) ft = "R6";
    else if (a[30:0] == 0 || b[30:0] == 0 || a[30:23] == 0 || b[30:23] == 0) ft = "R5";
    else                         ft = "R2";
    if (nan)                     stt = "R7";
    else if (refInf(a) || refInf(b)) stt = "R1";
    else                         stt = "R8";
    @(negedge clk);
    inValid  = 1'b1;
    opA      = a;
    opB      = b;
    predSel  = p;
    statusIn = st;
    expFlag.push_back(refFlag(a, b, p));
    expStat.push_back(st | (nan ? 8'h10 : 8'h00));
    flagTag.push_back($sformatf("%s flag a=%h b=%h p=%0d", ft, a, b, p));
    statTag.push_back($sformatf("%s status a=%h b=%h", stt, a, b));
    sent++;
  endtask

  function automatic logic [31:0] randOperand(logic [31:0] other);
    logic [31:0] r;
    r = $urandom;
    case ($urandom_range(0, 5))
      0: return r;
      1: return {r[31], 8'hFF, (r[22:0] == 0) ? 23'h1 : r[22:0]};
      2: return {r[31], 8'hFF, 23'h0};
      3: return {r[31], 31'h0};
      4: return {r[31], 8'h00, r[22:0]};
      default: return other + 32'($urandom_range(0, 2)) - 32'd1;
    endcase
  endfunction

  // monitor: pops the scoreboard whenever a result is presented
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && outValid) begin
        if (expFlag.size() == 0) begin
          total++; bad++;
          $display("FAIL R9 unexpected outValid actual=1 expected=0");
        end else begin
          check(flagTag.pop_front(), 32'(condFlag), 32'(expFlag.pop_front()));
          check(statTag.pop_front(), 32'(statusOut), 32'(expStat.pop_front()));
          obsFlag.push_back(condFlag);
          lastFlag = condFlag;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [31:0] vals [14] = '{
    32'h7FC0_0000, 32'h7F80_0001, 32'hFFC0_0000, 32'h7F80_0000, 32'hFF80_0000,
    32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h0040_0000, 32'h8000_0001,
    32'h3F80_0000, 32'hBF80_0000, 32'hC000_0000, 32'h7F7F_FFFF };

  initial begin
    rst_n = 1'b0; inValid = 1'b0; predSel = '0; opA = '0; opB = '0; statusIn = '0;
    repeat (3) @(negedge clk);
    check("R9 reset outValid", 32'(outValid), 0);
    check("R9 reset condFlag", 32'(condFlag), 0);
    check("R9 reset statusOut", 32'(statusOut), 0);
    rst_n = 1'b1;

    // directed corners across every predicate code
    for (int i = 0; i < 14; i++)
      for (int j = 0; j < 14; j++)
        for (int p = 0; p < 8; p++)
          send(vals[i], vals[j], 3'(p), 8'($urandom));

    // random pairs
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] a;
      a = $urandom;
      send(a, randOperand(a), 3'($urandom_range(0, 7)), 8'($urandom));
    end

    // R11 identity pairs: greater then less-or-equal on the same operands
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      a = randOperand($urandom);
      b = randOperand(a);
      pairIdx.push_back(sent);
      pairNan.push_back(refNan(a) || refNan(b));
      send(a, b, 3'd2, 8'h04);
      send(a, b, 3'd5, 8'h04);
    end

    @(negedge clk);
    inValid = 1'b0;
    opA = 32'h7FC0_0000; predSel = 3'd1; statusIn = 8'hFF;
    repeat (3) @(negedge clk);
    check("R9 idle outValid", 32'(outValid), 0);
    check("R9 idle condFlag held", 32'(condFlag), 32'(lastFlag));

    for (int k = 0; k < pairIdx.size(); k++) begin
      bit gt, le;
      gt = obsFlag[pairIdx[k]];
      le = obsFlag[pairIdx[k] + 1];
      check("R11 gt vs not unordered-le", 32'(gt), 32'(!(pairNan[k] || le)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule